// File: doc/BRIEF.md
# Activity-Triggered Throttle Inhibit Timers

This block stops CPU clock throttling for a short, programmable time after system activity. It holds two separate one-shot countdown timers. One watches interrupt-related activity and the other watches graphics activity. When a qualifying event arrives, suspend modulation is globally on and that source's speedup bit is set, the timer loads its 8-bit reload value. It then counts down once per 1 ms tick. While either timer is nonzero, the block raises a single registered inhibit output. The modulation generator downstream uses that output to let the CPU run at full speed.

The graphics source needs no help from outside: the block decodes legacy display I/O ports and the legacy display memory window itself, using a bus access strobe and its address. When a timer reaches zero, throttling simply resumes and nothing else is signalled. A new event while a timer is running reloads it to its full count.

Top module: `throttle_inhibit_timers`

## Requirements
- R1: After reset both timers are zero and `inhibit` is low.
- R2: An interrupt timer event loads the interrupt timer. Any one of these is an event: `irqPending` high, `smiEvt` high, `intrEvt` high, or `ioAccess` high with `busAddr[15:0]` == 0x0061. `inhibit` is high from the clock edge that samples the event when the reload value is nonzero.
- R3: A video timer event loads the video timer. Any one of these is an event: `gfxAccess` high; `ioAccess` high with `busAddr[15:0]` from 0x03B0 to 0x03DF; or `memAccess` high with `busAddr` from 0xA0000 to 0xB7FFF.
- R4: Accesses just outside those windows leave `inhibit` low. This covers I/O 0x0060, 0x03AF and 0x03E0, memory 0x9FFFF and 0xB8000, and a memory access at 0x003C0.
- R5: A timer loads only when `modEnable` is high and its own enable is high (`irqSpeedEn` for the interrupt timer, `vidSpeedEn` for the video timer). Otherwise events have no effect.
- R6: A running timer decrements on each cycle where `msTick` is high. After a load with value N, `inhibit` falls at the edge that samples the Nth tick.
- R7: An event while a timer is running reloads that timer to its full value.
- R8: A reload value of zero produces no inhibit period.
- R9: `inhibit` is the OR of the two timers' nonzero states, and the two timers count independently.
- R10: Without a tick and without a load, the timers and `inhibit` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle 1 ms timebase pulse |
| modEnable | input | 1 | Suspend modulation globally enabled |
| irqSpeedEn | input | 1 | Interrupt speedup enable |
| vidSpeedEn | input | 1 | Video speedup enable |
| irqReload | input | 8 | Interrupt timer reload value |
| vidReload | input | 8 | Video timer reload value |
| irqPending | input | 1 | Any unmasked interrupt request pending |
| smiEvt | input | 1 | System management interrupt event |
| intrEvt | input | 1 | CPU interrupt line event |
| ioAccess | input | 1 | I/O bus access strobe |
| memAccess | input | 1 | Memory bus access strobe |
| busAddr | input | 20 | Address of the current bus access |
| gfxAccess | input | 1 | Access to the integrated graphics controller |
| inhibit | output | 1 | Throttling inhibited (full speed) |

## Verification
Properties are checked on every cycle. They cover these behaviours:
- a qualified event with a nonzero reload raises `inhibit` on the next edge;
- with modulation off, an idle output never rises;
- with zero reload values, an idle output stays low;
- `inhibit` holds when there is neither a tick nor an enabled load;
- `inhibit` falls only after a tick or a zero reload.

The exact address window edges, the precise tick count before release, retrigger extension, and the way the two timers overlap depend on the count values. Only the bench's directed scenarios show those.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int NUM_SRC = 2;
  localparam int SRC_IRQ = 0;
  localparam int SRC_VID = 1;

  typedef struct packed {
    logic [NUM_SRC-1:0] load;
    logic               tick;
  } thrStrobe_t;
endpackage

// File: rtl/thr_ctrl.sv
module thr_ctrl
  import thr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IO_W   = 16
) (
  input  logic              msTick,
  input  logic              modEnable,
  input  logic              irqSpeedEn,
  input  logic              vidSpeedEn,
  input  logic              irqPending,
  input  logic              smiEvt,
  input  logic              intrEvt,
  input  logic              ioAccess,
  input  logic              memAccess,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              gfxAccess,
  output thrStrobe_t        strobes
);
  localparam logic [IO_W-1:0]   SPEAKER_PORT = IO_W'(16'h0061);
  localparam logic [IO_W-1:0]   VGA_IO_LO    = IO_W'(16'h03B0);
  localparam logic [IO_W-1:0]   VGA_IO_HI    = IO_W'(16'h03DF);
  localparam logic [ADDR_W-1:0] VGA_MEM_LO   = ADDR_W'(20'hA0000);
  localparam logic [ADDR_W-1:0] VGA_MEM_HI   = ADDR_W'(20'hB7FFF);

  logic [IO_W-1:0] ioPort;
  logic            portHit;
  logic            vgaIoHit;
  logic            vgaMemHit;
  logic            irqEvent;
  logic            vidEvent;

  assign ioPort    = busAddr[IO_W-1:0];
  assign portHit   = ioAccess && (ioPort == SPEAKER_PORT);
  assign vgaIoHit  = ioAccess && (ioPort >= VGA_IO_LO) && (ioPort <= VGA_IO_HI);
  assign vgaMemHit = memAccess && (busAddr >= VGA_MEM_LO) && (busAddr <= VGA_MEM_HI);

  assign irqEvent = irqPending || smiEvt || intrEvt || portHit;
  assign vidEvent = gfxAccess || vgaIoHit || vgaMemHit;

  always_comb begin
    strobes = '0;
    strobes.tick          = msTick;
    strobes.load[SRC_IRQ] = modEnable && irqSpeedEn && irqEvent;
    strobes.load[SRC_VID] = modEnable && vidSpeedEn && vidEvent;
  end
endmodule

// File: rtl/thr_datapath.sv
module thr_datapath
  import thr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  thrStrobe_t       strobes,
  input  logic [CNT_W-1:0] reloadVal [NUM_SRC],
  output logic             inhibit
);
  logic [CNT_W-1:0]   cnt     [NUM_SRC];
  logic [CNT_W-1:0]   cntNext [NUM_SRC];
  logic [NUM_SRC-1:0] busyNext;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gTimer
    always_comb begin
      if (strobes.load[g])
        cntNext[g] = reloadVal[g];
      else if (strobes.tick && (cnt[g] != '0))
        cntNext[g] = cnt[g] - CNT_W'(1);
      else
        cntNext[g] = cnt[g];
    end

    always_ff @(posedge clk) begin
      if (!rstN) cnt[g] <= '0;
      else       cnt[g] <= cntNext[g];
    end

    assign busyNext[g] = (cntNext[g] != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) inhibit <= 1'b0;
    else       inhibit <= |busyNext;
  end
endmodule

// File: rtl/throttle_inhibit_timers.sv
module throttle_inhibit_timers
  import thr_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  logic              modEnable,
  input  logic              irqSpeedEn,
  input  logic              vidSpeedEn,
  input  logic [CNT_W-1:0]  irqReload,
  input  logic [CNT_W-1:0]  vidReload,
  input  logic              irqPending,
  input  logic              smiEvt,
  input  logic              intrEvt,
  input  logic              ioAccess,
  input  logic              memAccess,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              gfxAccess,
  output logic              inhibit
);
  thrStrobe_t       strobes;
  logic [CNT_W-1:0] reloadVal [NUM_SRC];

  assign reloadVal[SRC_IRQ] = irqReload;
  assign reloadVal[SRC_VID] = vidReload;

  thr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .msTick(msTick), .modEnable(modEnable), .irqSpeedEn(irqSpeedEn),
    .vidSpeedEn(vidSpeedEn), .irqPending(irqPending), .smiEvt(smiEvt),
    .intrEvt(intrEvt), .ioAccess(ioAccess), .memAccess(memAccess),
    .busAddr(busAddr), .gfxAccess(gfxAccess), .strobes(strobes)
  );

  thr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reloadVal(reloadVal), .inhibit(inhibit)
  );
endmodule

// File: rtl/thr_inhibit_checker.sv
module thr_inhibit_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             msTick,
  input logic             modEnable,
  input logic             irqSpeedEn,
  input logic             vidSpeedEn,
  input logic [CNT_W-1:0] irqReload,
  input logic [CNT_W-1:0] vidReload,
  input logic             intrEvt,
  input logic             gfxAccess,
  input logic             inhibit
);
  AST_IRQ_LOAD_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (modEnable && irqSpeedEn && intrEvt && irqReload != '0) |=> inhibit); // R2
  AST_VID_LOAD_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (modEnable && vidSpeedEn && gfxAccess && vidReload != '0) |=> inhibit); // R3
  AST_NO_LOAD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!modEnable && !inhibit) |=> !inhibit); // R5
  AST_ZERO_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!inhibit && irqReload == '0 && vidReload == '0) |=> !inhibit); // R8
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!msTick && !modEnable) |=> $stable(inhibit)); // R10
  AST_FALL_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inhibit) |-> ($past(msTick) || $past(irqReload) == '0 || $past(vidReload) == '0)); // R6
endmodule

bind throttle_inhibit_timers thr_inhibit_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .msTick(msTick), .modEnable(modEnable),
  .irqSpeedEn(irqSpeedEn), .vidSpeedEn(vidSpeedEn), .irqReload(irqReload),
  .vidReload(vidReload), .intrEvt(intrEvt), .gfxAccess(gfxAccess),
  .inhibit(inhibit)
);

// File: tb/sim_throttle_inhibit_timers.sv
module sim_throttle_inhibit_timers;
  logic        clk = 1'b0;
  logic        rstN;
  logic        msTick, modEnable, irqSpeedEn, vidSpeedEn;
  logic [7:0]  irqReload, vidReload;
  logic        irqPending, smiEvt, intrEvt, ioAccess, memAccess, gfxAccess;
  logic [19:0] busAddr;
  logic        inhibit;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  throttle_inhibit_timers u0 (
    .clk(clk), .rstN(rstN), .msTick(msTick), .modEnable(modEnable),
    .irqSpeedEn(irqSpeedEn), .vidSpeedEn(vidSpeedEn), .irqReload(irqReload),
    .vidReload(vidReload), .irqPending(irqPending), .smiEvt(smiEvt),
    .intrEvt(intrEvt), .ioAccess(ioAccess), .memAccess(memAccess),
    .busAddr(busAddr), .gfxAccess(gfxAccess), .inhibit(inhibit)
  );

  typedef struct packed {
    logic        io;
    logic        mem;
    logic        gfx;
    logic [19:0] addr;
    logic        pend;
    logic        smi;
    logic        intr;
    logic        expInh;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t [NV-1:0] VECS = '{
    '{1'b0, 1'b0, 1'b0, 20'h00000, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2}, // R2 irq pending
    '{1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 1'b1, 1'b0, 1'b1, 4'd2}, // R2 smi
    '{1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2}, // R2 intr
    '{1'b1, 1'b0, 1'b0, 20'h00061, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2}, // R2 port 61
    '{1'b1, 1'b0, 1'b0, 20'h00060, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 port 60
    '{1'b0, 1'b0, 1'b1, 20'h00000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3}, // R3 gfx
    '{1'b1, 1'b0, 1'b0, 20'h003B0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3}, // R3 io low edge
    '{1'b1, 1'b0, 1'b0, 20'h003DF, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3}, // R3 io high edge
    '{1'b1, 1'b0, 1'b0, 20'h003AF, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 below io
    '{1'b1, 1'b0, 1'b0, 20'h003E0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 above io
    '{1'b0, 1'b1, 1'b0, 20'hA0000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3}, // R3 mem low edge
    '{1'b0, 1'b1, 1'b0, 20'hB7FFF, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3}, // R3 mem high edge
    '{1'b0, 1'b1, 1'b0, 20'h9FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 below mem
    '{1'b0, 1'b1, 1'b0, 20'hB8000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 above mem
    '{1'b0, 1'b1, 1'b0, 20'h003C0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4}  // R4 mem at io addr
  };

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: inhibit=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clearEvents();
    msTick = 0; irqPending = 0; smiEvt = 0; intrEvt = 0;
    ioAccess = 0; memAccess = 0; gfxAccess = 0; busAddr = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    clearEvents();
    rstN = 0;
    step(); step();
    rstN = 1;
  endtask

  task automatic tick();
    msTick = 1; step(); msTick = 0;
  endtask

  task automatic pulseIntr();
    intrEvt = 1; step(); intrEvt = 0;
  endtask

  task automatic pulseGfx();
    gfxAccess = 1; step(); gfxAccess = 0;
  endtask

  initial begin
    @(negedge clk);
    modEnable = 1; irqSpeedEn = 1; vidSpeedEn = 1;
    irqReload = 8'd3; vidReload = 8'd3;
    doReset();
    check("R1", inhibit, 1'b0);

    for (int i = 0; i < NV; i++) begin
      doReset();
      ioAccess = VECS[i].io; memAccess = VECS[i].mem; gfxAccess = VECS[i].gfx;
      busAddr = VECS[i].addr; irqPending = VECS[i].pend;
      smiEvt = VECS[i].smi; intrEvt = VECS[i].intr;
      step();
      clearEvents();
      check($sformatf("R%0d vec%0d", VECS[i].req, i), inhibit, VECS[i].expInh);
    end

    // R6 / R10: reload 3 lasts exactly three ticks; idle cycles hold
    doReset();
    pulseIntr();
    check("R6", inhibit, 1'b1);
    tick(); check("R6", inhibit, 1'b1);
    step(); step(); check("R10", inhibit, 1'b1);
    tick(); check("R6", inhibit, 1'b1);
    tick(); check("R6", inhibit, 1'b0);

    // R7: retrigger restores full count
    doReset();
    irqReload = 8'd4;
    pulseIntr();
    tick(); tick();
    pulseIntr();
    tick(); tick(); tick();
    check("R7", inhibit, 1'b1);
    tick(); check("R7", inhibit, 1'b0);

    // R8: zero reload gives no inhibit
    doReset();
    irqReload = 8'd0;
    pulseIntr(); check("R8", inhibit, 1'b0);

    // R5: global and per-source gating
    doReset();
    irqReload = 8'd3; vidReload = 8'd3;
    modEnable = 0;
    pulseIntr(); pulseGfx(); check("R5 global", inhibit, 1'b0);
    modEnable = 1; irqSpeedEn = 0;
    pulseIntr(); check("R5 irq en", inhibit, 1'b0);
    irqSpeedEn = 1; vidSpeedEn = 0;
    pulseGfx(); check("R5 vid en", inhibit, 1'b0);
    vidSpeedEn = 1;

    // R9: overlapping timers
    doReset();
    irqReload = 8'd2; vidReload = 8'd5;
    intrEvt = 1; gfxAccess = 1; step(); clearEvents();
    check("R9", inhibit, 1'b1);
    tick(); tick(); check("R9 vid holds", inhibit, 1'b1);
    tick(); tick(); check("R9", inhibit, 1'b1);
    tick(); check("R9 both done", inhibit, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule